// File: doc/BRIEF.md
# Cascadable Multiplier Operand Register Bank

This block captures the operands in front of a variable-precision multiplier. It holds two operand lanes. Each lane has a top leg and a bottom leg. Every leg can be registered, or it can bypass its register and drive the multiplier input in the same cycle. The top leg of each lane can take its value from the general data input or from a cascade input. That cascade input is fed by the cascade output of a neighbouring bank, so a row of banks forms a tap-delay line. The cascade output always carries this bank's top-leg stage value, whether that value is registered or bypassed.

A static mode input selects one of two layouts. In the narrow layout there are two independent 18-bit lanes, and both top legs may use the cascade. In the wide layout there is a single 27-bit operand in lane 0, lane 1 is held at zero, and only lane 0 can use the cascade. In the narrow layout an optional delay register follows each leg, after the cascade tap. This adds one cycle to the multiplier path without changing the cascade timing, which balances latency when the input cascade and an output chain are used together.

There is one clock. Three clock enables are shared by all registers, and each register class selects one of them. A single asynchronous clear empties every register.

Top module: `vpm_inreg_bank`

## Requirements
- R1: While `aclr` is high, and after it is released with no enable active, every register reads zero. With registering enabled, all outputs are then zero.
- R2: With a leg registered, its multiplier output shows the value that was present at its source on the last rising edge where the leg's selected enable was high.
- R3: With a leg bypassed, its multiplier output follows its source input in the same cycle, with no clock edge needed.
- R4: Each enable-select field picks the load condition of its register class. The codes are 0, 1 and 2 for `ena[0]`, `ena[1]` and `ena[2]`, and code 3 loads on every edge. A register holds its value on any edge where its selected enable is low.
- R5: Bit i of `cfg_casc` makes lane i's top leg take its value from `casc_in` instead of `top_data`, using the same bit positions.
- R6: `casc_out` equals each lane's top-leg stage value (registered or bypassed) and is never delayed by the delay register. When the delay is off, `casc_out` equals `mult_top`.
- R7: When `mode_wide`=1, lane 0 is 27 bits wide at bits [26:0] of every bus. Bits [35:27] of all outputs are zero. `cfg_casc[1]` and `cfg_dly` have no effect.
- R8: When `mode_wide`=0, lane 0 occupies bits [17:0] and lane 1 occupies bits [35:18] of every bus. The two lanes are registered and cascaded independently.
- R9: When `cfg_dly`=1 in narrow mode, each leg reaches its multiplier output exactly one selected-enable edge later than with `cfg_dly`=0. The delay registers use `cfg_dly_ensel`.
- R10: Raising `aclr` clears the registers at once, with no clock edge and whatever the enables are doing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers load on its rising edge |
| aclr | input | 1 | Asynchronous clear of all registers, active high |
| ena | input | 3 | Three clock enables |
| mode_wide | input | 1 | 1 selects the single 27-bit layout, 0 selects two 18-bit lanes |
| cfg_top_reg | input | 1 | 1 registers the top legs, 0 bypasses them |
| cfg_bot_reg | input | 1 | 1 registers the bottom legs, 0 bypasses them |
| cfg_dly | input | 1 | 1 inserts the extra delay register (narrow mode only) |
| cfg_casc | input | 2 | Per-lane top-leg source: 1 means cascade input |
| cfg_top_ensel | input | 2 | Enable select for the top-leg registers |
| cfg_bot_ensel | input | 2 | Enable select for the bottom-leg registers |
| cfg_dly_ensel | input | 2 | Enable select for the delay registers |
| top_data | input | 36 | General top-leg data, packed by lane |
| bot_data | input | 36 | Bottom-leg data, packed by lane |
| casc_in | input | 36 | Cascade input from the previous bank |
| casc_out | output | 36 | Cascade output to the next bank |
| mult_top | output | 36 | Top operands to the multiplier |
| mult_bot | output | 36 | Bottom operands to the multiplier |

## Verification
The hardest situation to reach is a tap-delay chain in which each link is clocked under a different enable and the delay register is also in use. In that case the value on the cascade and the value on the multiplier input of the same bank are deliberately a cycle apart. To create it, the bench chains two banks, feeding the first bank's cascade output into the second bank's cascade input. It then toggles the three enables at random while the delay is on, and a behavioural model of both banks predicts every output on every cycle. A clear raised between edges, with all enables low, is checked before the next edge arrives.

// File: rtl/vpm_inreg_pkg.sv
package vpm_inreg_pkg;

   localparam int EN_COUNT = 3;
   localparam int ENSEL_W  = 2;

   typedef enum logic [ENSEL_W-1:0] {
      ENSEL_E0  = 2'd0,
      ENSEL_E1  = 2'd1,
      ENSEL_E2  = 2'd2,
      ENSEL_ANY = 2'd3
   } ensel_e;

   // Resolve a register's load condition from the shared enables.
   function automatic logic pick_enable(input logic [EN_COUNT-1:0] ena,
                                        input logic [ENSEL_W-1:0]  sel);
      logic res;
      case (ensel_e'(sel))
         ENSEL_E0:  res = ena[0];
         ENSEL_E1:  res = ena[1];
         ENSEL_E2:  res = ena[2];
         default:   res = 1'b1;
      endcase
      return res;
   endfunction

endpackage

// File: rtl/vpm_opnd_stage.sv
module vpm_opnd_stage
   import vpm_inreg_pkg::*;
#(
   parameter int W = 18
) (
   input  logic                clk,
   input  logic                aclr,
   input  logic [EN_COUNT-1:0] ena,
   input  logic [ENSEL_W-1:0]  ensel,
   input  logic                use_reg,
   input  logic [W-1:0]        mask,
   input  logic [W-1:0]        d,
   output logic [W-1:0]        q_out
);

   if (W < 1) begin : g_bad_w
      $error("vpm_opnd_stage: W must be positive");
   end

   logic         load;
   logic [W-1:0] q;

   assign load = pick_enable(ena, ensel);

   always_ff @(posedge clk or posedge aclr) begin
      if (aclr)      q <= '0;
      else if (load) q <= d;
   end

   assign q_out = (use_reg ? q : d) & mask;

   AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (aclr)
      !load |=> $stable(q)); // R4

   AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (aclr)
      load |=> (q == $past(d))); // R2

endmodule

// File: rtl/vpm_inreg_lane.sv
module vpm_inreg_lane
   import vpm_inreg_pkg::*;
#(
   parameter int W = 18
) (
   input  logic                clk,
   input  logic                aclr,
   input  logic [EN_COUNT-1:0] ena,
   input  logic [W-1:0]        act_mask,
   input  logic                casc_sel,
   input  logic                top_reg,
   input  logic                bot_reg,
   input  logic                dly_on,
   input  logic [ENSEL_W-1:0]  top_ensel,
   input  logic [ENSEL_W-1:0]  bot_ensel,
   input  logic [ENSEL_W-1:0]  dly_ensel,
   input  logic [W-1:0]        top_raw,
   input  logic [W-1:0]        bot_raw,
   input  logic [W-1:0]        casc_raw,
   output logic [W-1:0]        casc_tap,
   output logic [W-1:0]        mul_top,
   output logic [W-1:0]        mul_bot
);

   logic [W-1:0] top_src, bot_src, top_stage, bot_stage;

   // Top-leg source: general routing or cascade from the previous bank.
   assign top_src = (casc_sel ? casc_raw : top_raw) & act_mask;
   assign bot_src = bot_raw & act_mask;

   vpm_opnd_stage #(.W(W)) u_top (
      .clk(clk), .aclr(aclr), .ena(ena), .ensel(top_ensel),
      .use_reg(top_reg), .mask(act_mask), .d(top_src), .q_out(top_stage));

   vpm_opnd_stage #(.W(W)) u_bot (
      .clk(clk), .aclr(aclr), .ena(ena), .ensel(bot_ensel),
      .use_reg(bot_reg), .mask(act_mask), .d(bot_src), .q_out(bot_stage));

   // Delay stages sit after the cascade tap, so only the multiplier path moves.
   vpm_opnd_stage #(.W(W)) u_dly_top (
      .clk(clk), .aclr(aclr), .ena(ena), .ensel(dly_ensel),
      .use_reg(dly_on), .mask(act_mask), .d(top_stage), .q_out(mul_top));

   vpm_opnd_stage #(.W(W)) u_dly_bot (
      .clk(clk), .aclr(aclr), .ena(ena), .ensel(dly_ensel),
      .use_reg(dly_on), .mask(act_mask), .d(bot_stage), .q_out(mul_bot));

   assign casc_tap = top_stage;

   AST_LANE_IDLE_ZERO: assert property (@(posedge clk) disable iff (aclr)
      (act_mask == '0) |-> (casc_tap == '0 && mul_top == '0 && mul_bot == '0)); // R7

endmodule

// File: rtl/vpm_inreg_bank.sv
module vpm_inreg_bank
   import vpm_inreg_pkg::*;
#(
   parameter  int NARROW = 18,
   parameter  int WIDE   = 27,
   localparam int CASC_W = 2 * NARROW
) (
   input  logic                clk,
   input  logic                aclr,
   input  logic [2:0]          ena,
   input  logic                mode_wide,
   input  logic                cfg_top_reg,
   input  logic                cfg_bot_reg,
   input  logic                cfg_dly,
   input  logic [1:0]          cfg_casc,
   input  logic [1:0]          cfg_top_ensel,
   input  logic [1:0]          cfg_bot_ensel,
   input  logic [1:0]          cfg_dly_ensel,
   input  logic [CASC_W-1:0]   top_data,
   input  logic [CASC_W-1:0]   bot_data,
   input  logic [CASC_W-1:0]   casc_in,
   output logic [CASC_W-1:0]   casc_out,
   output logic [CASC_W-1:0]   mult_top,
   output logic [CASC_W-1:0]   mult_bot
);

   localparam int NLANE = 2;

   if (WIDE <= NARROW || WIDE > CASC_W) begin : g_bad_width
      $error("vpm_inreg_bank: WIDE must exceed NARROW and fit two narrow lanes");
   end
   if (EN_COUNT != 3) begin : g_bad_en
      $error("vpm_inreg_bank: port list expects three enables");
   end

   logic              dly_on;
   logic [CASC_W-1:0] pk_casc [NLANE];
   logic [CASC_W-1:0] pk_top  [NLANE];
   logic [CASC_W-1:0] pk_bot  [NLANE];

   assign dly_on = cfg_dly & ~mode_wide;

   for (genvar i = 0; i < NLANE; i++) begin : g_lane
      localparam int LW = (i == 0) ? WIDE : NARROW;
      localparam int LO = (i == 0) ? 0 : NARROW;

      logic [LW-1:0] msk, ctap, mt, mb;

      if (i == 0) begin : g_msk_lo
         assign msk = mode_wide ? {LW{1'b1}} : LW'({NARROW{1'b1}});
      end else begin : g_msk_hi
         assign msk = mode_wide ? {LW{1'b0}} : {LW{1'b1}};
      end

      vpm_inreg_lane #(.W(LW)) u_lane (
         .clk(clk), .aclr(aclr), .ena(ena), .act_mask(msk),
         .casc_sel(cfg_casc[i]), .top_reg(cfg_top_reg), .bot_reg(cfg_bot_reg),
         .dly_on(dly_on), .top_ensel(cfg_top_ensel), .bot_ensel(cfg_bot_ensel),
         .dly_ensel(cfg_dly_ensel),
         .top_raw(top_data[LO +: LW]), .bot_raw(bot_data[LO +: LW]),
         .casc_raw(casc_in[LO +: LW]),
         .casc_tap(ctap), .mul_top(mt), .mul_bot(mb));

      assign pk_casc[i] = CASC_W'(ctap) << LO;
      assign pk_top[i]  = CASC_W'(mt) << LO;
      assign pk_bot[i]  = CASC_W'(mb) << LO;
   end

   always_comb begin
      casc_out = '0;
      mult_top = '0;
      mult_bot = '0;
      for (int k = 0; k < NLANE; k++) begin
         casc_out = casc_out | pk_casc[k];
         mult_top = mult_top | pk_top[k];
         mult_bot = mult_bot | pk_bot[k];
      end
   end

   AST_WIDE_UPPER_ZERO: assert property (@(posedge clk) disable iff (aclr)
      mode_wide |-> (mult_top[CASC_W-1:WIDE] == '0 && mult_bot[CASC_W-1:WIDE] == '0
                     && casc_out[CASC_W-1:WIDE] == '0)); // R7

   AST_TAP_MATCHES_MULT: assert property (@(posedge clk) disable iff (aclr)
      !dly_on |-> (casc_out == mult_top)); // R6

endmodule

// File: tb/vpm_inreg_bank_tb.sv
module vpm_inreg_bank_tb;

   localparam int CLK_P = 10;
   localparam int CW    = 36;
   localparam int NW    = 18;
   localparam int WW    = 27;

   logic clk = 1'b0;
   logic aclr = 1'b1;
   logic [2:0] ena = 3'b000;
   logic mode_wide = 1'b0, top_reg = 1'b1, bot_reg = 1'b1, dly = 1'b0;
   logic [1:0] tsel = 2'd3, bsel = 2'd3, dsel = 2'd3;
   logic [1:0] csel [2];
   logic [CW-1:0] tdat [2];
   logic [CW-1:0] bdat [2];
   logic [CW-1:0] casc_in0 = '0;
   logic [CW-1:0] c_out [2];
   logic [CW-1:0] m_top [2];
   logic [CW-1:0] m_bot [2];

   logic [CW-1:0] s_tq [2] = '{default: '0};
   logic [CW-1:0] s_bq [2] = '{default: '0};
   logic [CW-1:0] s_td [2] = '{default: '0};
   logic [CW-1:0] s_bd [2] = '{default: '0};

   int checks = 0, failures = 0;
   string phase = "R1";

   always #(CLK_P/2) clk = ~clk;

   vpm_inreg_bank u_dut (
      .clk(clk), .aclr(aclr), .ena(ena), .mode_wide(mode_wide),
      .cfg_top_reg(top_reg), .cfg_bot_reg(bot_reg), .cfg_dly(dly),
      .cfg_casc(csel[0]), .cfg_top_ensel(tsel), .cfg_bot_ensel(bsel),
      .cfg_dly_ensel(dsel), .top_data(tdat[0]), .bot_data(bdat[0]),
      .casc_in(casc_in0), .casc_out(c_out[0]), .mult_top(m_top[0]),
      .mult_bot(m_bot[0]));

   // Second bank fed from the first: a two-tap delay line.
   vpm_inreg_bank u_nxt (
      .clk(clk), .aclr(aclr), .ena(ena), .mode_wide(mode_wide),
      .cfg_top_reg(top_reg), .cfg_bot_reg(bot_reg), .cfg_dly(dly),
      .cfg_casc(csel[1]), .cfg_top_ensel(tsel), .cfg_bot_ensel(bsel),
      .cfg_dly_ensel(dsel), .top_data(tdat[1]), .bot_data(bdat[1]),
      .casc_in(c_out[0]), .casc_out(c_out[1]), .mult_top(m_top[1]),
      .mult_bot(m_bot[1]));

   // ---------------- behavioural reference ----------------
   function automatic logic [CW-1:0] all_mask();
      return mode_wide ? ((CW'(1) << WW) - 1) : {CW{1'b1}};
   endfunction

   function automatic logic en_of(input logic [1:0] s);
      return (s == 2'd3) ? 1'b1 : ena[s];
   endfunction

   function automatic logic [CW-1:0] exp_casc(input int b);
      logic [CW-1:0] cin, f0, f1, src;
      cin = (b == 0) ? casc_in0 : exp_casc(0);
      f0  = mode_wide ? ((CW'(1) << WW) - 1) : ((CW'(1) << NW) - 1);
      f1  = mode_wide ? '0 : ~((CW'(1) << NW) - 1);
      src = ((csel[b][0] ? cin : tdat[b]) & f0)
          | (((csel[b][1] && !mode_wide) ? cin : tdat[b]) & f1);
      return (top_reg ? s_tq[b] : src) & all_mask();
   endfunction

   function automatic logic [CW-1:0] top_src(input int b);
      logic [CW-1:0] cin, f0, f1;
      cin = (b == 0) ? casc_in0 : exp_casc(0);
      f0  = mode_wide ? ((CW'(1) << WW) - 1) : ((CW'(1) << NW) - 1);
      f1  = mode_wide ? '0 : ~((CW'(1) << NW) - 1);
      return ((csel[b][0] ? cin : tdat[b]) & f0)
           | (((csel[b][1] && !mode_wide) ? cin : tdat[b]) & f1);
   endfunction

   function automatic logic [CW-1:0] exp_bstage(input int b);
      return (bot_reg ? s_bq[b] : bdat[b]) & all_mask();
   endfunction

   function automatic logic dly_live();
      return dly && !mode_wide;
   endfunction

   function automatic logic [CW-1:0] exp_mtop(input int b);
      return dly_live() ? (s_td[b] & all_mask()) : exp_casc(b);
   endfunction

   function automatic logic [CW-1:0] exp_mbot(input int b);
      return dly_live() ? (s_bd[b] & all_mask()) : exp_bstage(b);
   endfunction

   always @(posedge clk or posedge aclr) begin
      if (aclr) begin
         s_tq <= '{default: '0}; s_bq <= '{default: '0};
         s_td <= '{default: '0}; s_bd <= '{default: '0};
      end else begin
         logic [CW-1:0] ntq [2], nbq [2], ntd [2], nbd [2];
         for (int b = 0; b < 2; b++) begin
            ntq[b] = en_of(tsel) ? top_src(b) : s_tq[b];
            nbq[b] = en_of(bsel) ? (bdat[b] & all_mask()) : s_bq[b];
            ntd[b] = en_of(dsel) ? exp_casc(b) : s_td[b];
            nbd[b] = en_of(dsel) ? exp_bstage(b) : s_bd[b];
         end
         s_tq <= ntq; s_bq <= nbq; s_td <= ntd; s_bd <= nbd;
      end
   end

   // ---------------- checking ----------------
   task automatic cmp(input string tag, input string what,
                      input logic [CW-1:0] act, input logic [CW-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s act=%h exp=%h t=%0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic check_all();
      for (int b = 0; b < 2; b++) begin
         cmp(phase, $sformatf("bank%0d casc_out", b), c_out[b], exp_casc(b));
         cmp(phase, $sformatf("bank%0d mult_top", b), m_top[b], exp_mtop(b));
         cmp(phase, $sformatf("bank%0d mult_bot", b), m_bot[b], exp_mbot(b));
      end
   endtask

   task automatic step();
      @(negedge clk);
      check_all();
   endtask

   function automatic logic [CW-1:0] rnd();
      logic [63:0] t;
      t = {$urandom(), $urandom()};
      return t[CW-1:0];
   endfunction

   task automatic shuffle();
      for (int b = 0; b < 2; b++) begin
         tdat[b] = rnd();
         bdat[b] = rnd();
      end
      casc_in0 = rnd();
   endtask

   task automatic clear_pulse();
      @(negedge clk);
      aclr = 1'b1;
      @(negedge clk);
      @(negedge clk);
      aclr = 1'b0;
   endtask

   initial begin
      csel[0] = 2'b00; csel[1] = 2'b00;
      tdat[0] = '0; tdat[1] = '0; bdat[0] = '0; bdat[1] = '0;
      repeat (3) @(negedge clk);
      aclr = 1'b0;

      // R1: cleared registers, no enable active
      phase = "R1";
      for (int i = 0; i < 3; i++) begin shuffle(); step(); end

      // R2 / R8: narrow lanes registered, always-load enables
      phase = "R2_R8";
      tsel = 2'd3; bsel = 2'd3; dsel = 2'd3;
      for (int i = 0; i < 20; i++) begin shuffle(); step(); end

      // R3: bypass both legs
      phase = "R3";
      top_reg = 1'b0; bot_reg = 1'b0;
      for (int i = 0; i < 10; i++) begin shuffle(); #1; check_all(); step(); end
      top_reg = 1'b1; bot_reg = 1'b1;

      // R4: distinct enable per register class, toggled enables
      phase = "R4";
      tsel = 2'd1; bsel = 2'd2; dsel = 2'd0;
      for (int i = 0; i < 60; i++) begin
         ena = 3'($urandom());
         shuffle(); step();
      end

      // R5 / R6: tap-delay chain across two banks
      phase = "R5_R6";
      csel[0] = 2'b01; csel[1] = 2'b11; tsel = 2'd3;
      for (int i = 0; i < 30; i++) begin shuffle(); step(); end
      csel[0] = 2'b10;
      top_reg = 1'b0;
      for (int i = 0; i < 10; i++) begin shuffle(); step(); end
      top_reg = 1'b1;

      // R9: delay registers on, random enables
      phase = "R9";
      dly = 1'b1; dsel = 2'd3; tsel = 2'd3; bsel = 2'd3;
      for (int i = 0; i < 20; i++) begin shuffle(); step(); end
      tsel = 2'd0; dsel = 2'd2; bsel = 2'd1;
      for (int i = 0; i < 60; i++) begin
         ena = 3'($urandom());
         shuffle(); step();
      end

      // R9: explicit one-extra-cycle latency
      tsel = 2'd3; dsel = 2'd3; csel[0] = 2'b00; csel[1] = 2'b00;
      tdat[0] = 36'h0_0001_2345; step();
      tdat[0] = 36'h0_0000_0000; step();
      cmp("R9", "bank0 mult_top one edge later", m_top[0], 36'h0_0001_2345);
      dly = 1'b0;

      // R10: clear between edges, enables idle
      phase = "R10";
      ena = 3'b000; tsel = 2'd1; bsel = 2'd2; dsel = 2'd0;
      tdat[0] = 36'hA_BCDE_F012; bdat[0] = 36'h1_2345_6789;
      ena = 3'b111; step(); ena = 3'b000; step();
      @(negedge clk);
      aclr = 1'b1;
      #1;
      cmp("R10", "bank0 mult_top after clear", m_top[0], '0);
      cmp("R10", "bank0 mult_bot after clear", m_bot[0], '0);
      @(negedge clk);
      aclr = 1'b0;
      for (int i = 0; i < 3; i++) step();

      // R7: wide layout, lane 1 cascade select and delay ignored
      phase = "R7";
      mode_wide = 1'b1;
      clear_pulse();
      tsel = 2'd3; bsel = 2'd3; dsel = 2'd3; dly = 1'b1;
      csel[0] = 2'b10; csel[1] = 2'b11;
      for (int i = 0; i < 20; i++) begin shuffle(); step(); end
      tdat[0] = {CW{1'b1}}; bdat[0] = {CW{1'b1}}; csel[0] = 2'b10;
      step(); step();
      cmp("R7", "bank0 mult_top wide", m_top[0], 36'h0_07FF_FFFF);
      cmp("R7", "bank0 mult_bot wide", m_bot[0], 36'h0_07FF_FFFF);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(CLK_P * 150000);
      checks++;
      failures++;
      $display("FAIL watchdog expired in phase %s", phase);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule